// File: doc/BRIEF.md
# Pipelined Shift-Add FIR Filter

This block is a fixed-coefficient FIR filter in transposed form. Each tap applies a constant gain to the current input sample. The gain comes from a 16-bit coefficient given at elaboration. Instead of a general multiplier, every tap uses a short network of shifts and add/subtract operations. To keep that network small, each coefficient is first cut down to 10 bits. It is then recoded into signed digits, and only the three most significant nonzero digits are kept, so each product is formed from at most three shifted copies of the sample.

Registers are placed so that no register-to-register path passes through more than one adder. A product takes two register stages. Adding it into the sum passed from the neighbouring tap takes a third. A sample strobe travels alongside the data through a matching three-stage shift register. Each pipeline stage advances only on a strobed sample, so gaps in the input stream do not change the filtered sequence. The output is the full-precision two's-complement sum.

Top module: `csd_fir`

## Requirements
- R1: Each 16-bit coefficient is shortened by an arithmetic right shift of 6 bits, that is floor(raw/64). For example, 16'hFFA3 becomes -2 and 16'h0A40 becomes 41.
- R2: The shortened coefficient's magnitude is recoded into non-adjacent signed digits in {-1, 0, +1}. The three most significant nonzero digits are kept, and the sign of the shortened value is reapplied. For example, 87 (-1 at bits 0, 3, 5 and +1 at bit 7) becomes 128-32-8 = 88, and 511 becomes 512-1 = 511.
- R3: For the n-th accepted sample, the output equals the sum over k of eff_k * x[n-k]. Here eff_k is tap k's effective coefficient from R1/R2, tap 0 is the lowest 16 bits of the coefficient vector, and samples before reset count as zero.
- R4: out_valid is high exactly 3 clock edges after each cycle with in_valid high, and at no other time.
- R5: Only cycles with in_valid high are samples. An input stream with idle gaps gives the same output values, in the same order, as the same samples sent back to back.
- R6: out_data keeps its value on every cycle in which out_valid is low.
- R7: With rst_n low at a clock edge, out_valid and out_data are cleared and all sample history is discarded. in_valid is ignored while reset is held.
- R8: The output is OUT_W = IN_W+12+clog2(NTAPS) bits wide and exact for every input value, including full-scale inputs whose signs match the coefficient signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_data as a new sample |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Marks out_data as a new filtered value |
| out_data | output | OUT_W | Signed full-precision filter output |

## Verification
The case that is hardest to reach from the ports is the largest possible sum. It only occurs when five consecutive samples are each at full scale with the sign of their own coefficient. The stimulus therefore sends that exact sequence, and then its negation.

A second hard case is reset asserted while samples are still inside the three-stage pipeline. The bench resets in mid-stream and then sends an impulse, which shows that no earlier sample leaks into the new response. Random gaps in in_valid create bubbles at every pipeline stage.

// File: rtl/csd_fir_pkg.sv
// Shared types and elaboration-time functions for the shift-add FIR.
// Assumes coefficients arrive as 16-bit two's-complement words.
package csd_fir_pkg;

    // One retained signed digit: present flag, minus flag, bit weight.
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [3:0] sh;
    } term_t;

    // Recoded coefficient: overall sign plus up to three digits, most significant first.
    typedef struct packed {
        logic  cneg;
        term_t t0;
        term_t t1;
        term_t t2;
    } recode_t;

    // Drop the six low bits (arithmetic shift).
    function automatic logic signed [9:0] shorten(input logic [15:0] raw);
        return raw[15:6];
    endfunction

    // Non-adjacent recoding of the magnitude, keeping the top three nonzero digits.
    function automatic recode_t recode(input logic [15:0] raw);
        logic signed [9:0]  c;
        logic signed [11:0] cx;
        logic [11:0]        m;
        logic [11:0]        pos;
        logic [11:0]        neg;
        term_t              t;
        recode_t            r;
        int                 found;
        c      = shorten(raw);
        cx     = {{2{c[9]}}, c};
        m      = c[9] ? 12'(-cx) : 12'(cx);
        pos    = '0;
        neg    = '0;
        r      = '0;
        r.cneg = c[9];
        for (int i = 0; i < 12; i++) begin
            if (m[0]) begin
                if (m[1]) begin
                    neg[i] = 1'b1;
                    m      = m + 12'd1;
                end else begin
                    pos[i] = 1'b1;
                    m      = m - 12'd1;
                end
            end
            m = m >> 1;
        end
        found = 0;
        for (int i = 11; i >= 0; i--) begin
            if (pos[i] || neg[i]) begin
                t.en  = 1'b1;
                t.neg = neg[i];
                t.sh  = 4'(i);
                if (found == 0)      r.t0 = t;
                else if (found == 1) r.t1 = t;
                else if (found == 2) r.t2 = t;
                found++;
            end
        end
        return r;
    endfunction

    // Value of the retained digits without the overall sign.
    function automatic int mag_value(input recode_t r);
        int v;
        v = 0;
        if (r.t0.en) v = r.t0.neg ? v - (1 << r.t0.sh) : v + (1 << r.t0.sh);
        if (r.t1.en) v = r.t1.neg ? v - (1 << r.t1.sh) : v + (1 << r.t1.sh);
        if (r.t2.en) v = r.t2.neg ? v - (1 << r.t2.sh) : v + (1 << r.t2.sh);
        return v;
    endfunction

endpackage

// File: rtl/csd_fir_addsub.sv
// Ripple-carry adder/subtractor: y = a + b or a - b (modulo 2^W).
// Kept as its own module so another adder architecture can replace it.
module csd_fir_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] bx;
    logic [W-1:0] c;

    assign bx   = b ^ {W{sub}};
    assign c[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign y[i] = a[i] ^ bx[i] ^ c[i];
        if (i < W - 1) begin : g_carry
            assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
        end
    end

    // Ripple chain agrees with the arithmetic sum.
    always_comb begin
        assert_ripple_R3: assert (y == (sub ? a - b : a + b));
    end

endmodule

// File: rtl/csd_fir_cmult.sv
// Constant multiplier: |eff| * x with up to three shifted terms, two register stages.
// Stage A adds the two leading terms; stage B adds the third. Leading digit is positive.
module csd_fir_cmult
    import csd_fir_pkg::*;
#(
    parameter int          IN_W   = 8,
    parameter int          PROD_W = 20,
    parameter logic [15:0] RAW    = 16'h0040
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_a,
    input  logic                     en_b,
    input  logic signed [IN_W-1:0]   x,
    output logic signed [PROD_W-1:0] prod
);
    localparam recode_t                   RC  = recode(RAW);
    localparam logic signed [PROD_W-1:0] MAG = PROD_W'(mag_value(RC));

    logic signed [PROD_W-1:0] xe, p0, p1, p2;
    logic signed [PROD_W-1:0] s_a, s_b, sum_q, p2_q;

    assign xe = PROD_W'(x);
    assign p0 = RC.t0.en ? (xe <<< RC.t0.sh) : '0;
    assign p1 = RC.t1.en ? (xe <<< RC.t1.sh) : '0;
    assign p2 = RC.t2.en ? (xe <<< RC.t2.sh) : '0;

    csd_fir_addsub #(.W(PROD_W)) u_add_a (.a(p0),    .b(p1),   .sub(RC.t1.neg), .y(s_a));
    csd_fir_addsub #(.W(PROD_W)) u_add_b (.a(sum_q), .b(p2_q), .sub(RC.t2.neg), .y(s_b));

    // Stage A: first partial sum and the delayed third term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            p2_q  <= '0;
        end else if (en_a) begin
            sum_q <= s_a;
            p2_q  <= p2;
        end
    end

    // Stage B: complete product.
    always_ff @(posedge clk) begin
        if (!rst_n)    prod <= '0;
        else if (en_b) prod <= s_b;
    end

    // Product two stages later matches the recoded magnitude times the sample.
    assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_a |-> ##2 (prod == MAG * $past(x, 2)));

endmodule

// File: rtl/csd_fir_tap.sv
// One transposed-form tap: constant product plus the neighbour's registered sum.
// Coefficient sign is applied here by choosing add or subtract.
module csd_fir_tap
    import csd_fir_pkg::*;
#(
    parameter int          IN_W   = 8,
    parameter int          PROD_W = 20,
    parameter int          ACC_W  = 23,
    parameter logic [15:0] RAW    = 16'h0040
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_a,
    input  logic                    en_b,
    input  logic                    en_c,
    input  logic signed [IN_W-1:0]  x,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic signed [ACC_W-1:0] acc_out
);
    localparam recode_t RC = recode(RAW);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x, acc_d;

    csd_fir_cmult #(.IN_W(IN_W), .PROD_W(PROD_W), .RAW(RAW)) u_mult (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .x(x), .prod(prod)
    );

    assign prod_x = ACC_W'(prod);

    csd_fir_addsub #(.W(ACC_W)) u_acc (.a(acc_in), .b(prod_x), .sub(RC.cneg), .y(acc_d));

    // Stage C: registered running sum handed to the next tap.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_out <= '0;
        else if (en_c) acc_out <= acc_d;
    end

    // Sum register only moves on a valid accumulation step.
    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |=> $stable(acc_out));

endmodule

// File: rtl/csd_fir.sv
// Top: NTAPS transposed taps sharing the input, with a 3-stage valid pipeline.
// Assumes COEFS packs tap 0 in its lowest 16 bits; output is full precision.
module csd_fir #(
    parameter int                  NTAPS = 5,
    parameter int                  IN_W  = 8,
    parameter logic [NTAPS*16-1:0] COEFS = {16'hFFA3, 16'h15C0, 16'h7FC0, 16'hF400, 16'h0A40},
    parameter int                  OUT_W = IN_W + 12 + $clog2(NTAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int PROD_W = IN_W + 12;
    localparam int LAT    = 3;

    logic [LAT-1:0]          v_q;
    logic signed [OUT_W-1:0] chain [NTAPS+1];

    // Valid shift register matched to the data latency.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[LAT-2:0], in_valid};
    end

    assign chain[NTAPS] = '0;

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        csd_fir_tap #(
            .IN_W(IN_W), .PROD_W(PROD_W), .ACC_W(OUT_W), .RAW(COEFS[k*16 +: 16])
        ) u_tap (
            .clk(clk), .rst_n(rst_n),
            .en_a(in_valid), .en_b(v_q[0]), .en_c(v_q[1]),
            .x(in_data), .acc_in(chain[k+1]), .acc_out(chain[k])
        );
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = chain[0];

    // Every accepted sample yields an output three edges later.
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // No output strobe without a sample three edges earlier.
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // Output data frozen while no result is presented.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/sim_csd_fir.sv
`timescale 1ns/1ps
module sim_csd_fir;
    localparam int                  NTAPS = 5;
    localparam int                  IN_W  = 8;
    localparam int                  OUT_W = IN_W + 12 + $clog2(NTAPS);
    localparam logic [NTAPS*16-1:0] COEFS = {16'hFFA3, 16'h15C0, 16'h7FC0, 16'hF400, 16'h0A40};
    // Effective coefficients worked out by hand from R1/R2, tap 0 first.
    localparam int EFF [NTAPS] = '{41, -48, 511, 88, -2};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    int      checks = 0;
    int      failures = 0;
    int      ncyc = 0;
    int      hist [NTAPS];
    bit      exp_v [64];
    longint  exp_d [64];
    longint  last_d = 0;
    string   cur_req = "R7";
    bit      done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    csd_fir #(.NTAPS(NTAPS), .IN_W(IN_W), .COEFS(COEFS), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) ncyc <= ncyc + 1;

    task automatic clear_model();
        for (int i = 0; i < NTAPS; i++) hist[i] = 0;
        for (int i = 0; i < 64; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = 0;
        end
        last_d = 0;
    endtask

    task automatic check_outputs();
        int idx;
        idx = ncyc % 64;
        checks++;
        if (out_valid !== exp_v[idx]) begin
            failures++;
            $display("FAIL R4: out_valid=%0b expected=%0b at cycle %0d", out_valid, exp_v[idx], ncyc);
        end
        checks++;
        if (exp_v[idx]) begin
            if (longint'(out_data) != exp_d[idx]) begin
                failures++;
                $display("FAIL %s: out_data=%0d expected=%0d at cycle %0d",
                         cur_req, out_data, exp_d[idx], ncyc);
            end
            last_d = longint'(out_data);
        end else if (longint'(out_data) != last_d) begin
            failures++;
            $display("FAIL R6: out_data=%0d expected held %0d at cycle %0d", out_data, last_d, ncyc);
        end
        exp_v[idx] = 1'b0;
    endtask

    // One cycle: check what the last edge produced, then apply new inputs.
    task automatic drive(input bit v, input logic signed [IN_W-1:0] x);
        longint y;
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_data  = x;
        if (v) begin
            for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'(x);
            y = 0;
            for (int k = 0; k < NTAPS; k++) y += longint'(EFF[k]) * longint'(hist[k]);
            exp_v[(ncyc + 3) % 64] = 1'b1;
            exp_d[(ncyc + 3) % 64] = y;
        end
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0);
    endtask

    // R7: reset with junk strobes, check cleared outputs, then release.
    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'sd77;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R7: out_valid=%0b expected=0 during reset", out_valid);
        end
        checks++;
        if (out_data !== '0) begin
            failures++;
            $display("FAIL R7: out_data=%0d expected=0 during reset", out_data);
        end
        clear_model();
        rst_n    = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_model();
        cur_req = "R7";
        do_reset();

        // R1/R2: unit impulse reads out the effective coefficients.
        cur_req = "R1/R2";
        drive(1'b1, 8'sd1);
        for (int i = 0; i < NTAPS + 1; i++) drive(1'b1, '0);
        flush(5);

        // R8: negative full-scale impulse.
        cur_req = "R8";
        drive(1'b1, -8'sd128);
        for (int i = 0; i < NTAPS + 1; i++) drive(1'b1, '0);
        flush(5);

        // R3: step held at the positive limit.
        cur_req = "R3";
        for (int i = 0; i < 10; i++) drive(1'b1, 8'sd127);
        flush(5);

        // R3: dense sweep over every input code.
        cur_req = "R3";
        for (int i = -128; i < 128; i++) drive(1'b1, 8'(i));
        flush(5);

        // R5: random samples with random idle gaps.
        cur_req = "R5";
        for (int i = 0; i < 600; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            drive(seed[30] | seed[29], 8'(seed[23:16]));
        end
        flush(5);

        // R8: sign-matched full-scale run for the largest sum, then its negation.
        cur_req = "R8";
        drive(1'b1, -8'sd128); drive(1'b1, 8'sd127); drive(1'b1, 8'sd127);
        drive(1'b1, -8'sd128); drive(1'b1, 8'sd127);
        drive(1'b1, 8'sd127); drive(1'b1, -8'sd128); drive(1'b1, -8'sd128);
        drive(1'b1, 8'sd127); drive(1'b1, -8'sd128);
        flush(5);

        // R7: reset with samples in flight, then an impulse shows no leftover history.
        cur_req = "R7";
        for (int i = 0; i < 4; i++) drive(1'b1, 8'sd100);
        do_reset();
        drive(1'b1, 8'sd3);
        for (int i = 0; i < NTAPS + 1; i++) drive(1'b1, '0);
        flush(6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule